// File: doc/BRIEF.md
# Parallel Port FIFO Transmitter (Compatibility Mode)

This block is the host-side transmit engine of a standard printer-style parallel port running in its FIFO mode. Bytes come into a small transmit FIFO through a write port that a DMA controller services. The block raises a DMA request whenever the FIFO has room. The engine takes bytes off the head of the FIFO one at a time. It puts each byte on the 8-bit data lines, waits a programmed setup time, and pulls the active-low strobe low for a programmed width. It then raises the strobe again and holds the data for a programmed hold time.

Transfers are paced by the printer's Busy line alone. The block has no acknowledge input, and a new byte is launched only after the synchronised Busy reads low. Transfers only go from host to printer. The engine runs only while the 3-bit port mode input carries the FIFO-mode code. At 125 MHz, each of the three 8-bit phase counters can stretch its phase to 256 cycles. A byte period near 2 µs, which is about 500 Kbytes/s, is therefore well within range.

Top module: `pfifo_tx`

## Requirements
- R1: The block is active only while `mode_i` equals 3'b101. While it is inactive, `dma_req_o` is low in the same cycle, writes are dropped, and queued bytes are discarded. The strobe is also high from the next clock edge on, even if a strobe pulse was in progress.
- R2: `dma_req_o` is high exactly when the block is active and the FIFO holds fewer than `FIFO_DEPTH` bytes. The flag follows the FIFO fill level in the same cycle.
- R3: Bytes leave in the order they were written. A write made while the FIFO is full is dropped, and the FIFO never holds more than `FIFO_DEPTH` bytes.
- R4: A launch loads the head byte onto `pd_o`. `stb_n_o` falls exactly `setup_cyc_i`+1 clock edges after that update, and `pd_o` stays unchanged while `stb_n_o` is low.
- R5: `stb_n_o` stays low for exactly `width_cyc_i`+1 cycles.
- R6: After `stb_n_o` rises, `pd_o` holds its value for at least `hold_cyc_i`+1 cycles. If the next byte is queued and Busy is low, the next `pd_o` update comes exactly `hold_cyc_i`+2 edges after the rise.
- R7: Busy passes through a two-flop synchroniser. No byte is launched while Busy is high. When Busy falls with a byte queued and the engine idle, the launch happens on the third rising edge after the fall.
- R8: When the FIFO is empty, the engine stays idle with `stb_n_o` high and `pd_o` still showing the last byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mode_i | input | 3 | Port mode; 3'b101 enables the block |
| wr_en_i | input | 1 | FIFO write strobe from DMA |
| wr_data_i | input | DATA_W | Byte to queue |
| dma_req_o | output | 1 | DMA request: FIFO has room |
| setup_cyc_i | input | TIME_W | Data-to-strobe setup, cycles minus one |
| width_cyc_i | input | TIME_W | Strobe low width, cycles minus one |
| hold_cyc_i | input | TIME_W | Data hold after strobe rise, cycles minus one |
| busy_i | input | 1 | Printer Busy, asynchronous |
| pd_o | output | DATA_W | Parallel data lines |
| stb_n_o | output | 1 | Active-low data strobe |

## Verification
Each result arrives a fixed number of edges after its cause:
- `dma_req_o` changes in the same cycle as a write or a mode change.
- The strobe falls `setup_cyc_i`+1 edges after the data update, and it stays low for `width_cyc_i`+1 cycles.
- The next data update follows the strobe rise by `hold_cyc_i`+2 edges.
- A launch comes three edges after Busy falls.
- Leaving the mode forces the strobe high at the next edge.

The bench keeps an edge counter and samples every output on the falling clock edge. It stamps each data change and each strobe edge with the count and compares the differences against those values. Level checks such as the DMA request or the drop of a stale transfer are sampled on the falling edge right after the edge that must have caused them.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam logic [2:0] PFT_MODE_FIFO = 3'b101;

  typedef enum logic [1:0] {
    PFT_IDLE   = 2'd0,
    PFT_SETUP  = 2'd1,
    PFT_STROBE = 2'd2,
    PFT_HOLD   = 2'd3
  } pft_state_e;
endpackage

// File: rtl/pft_sync.sv
module pft_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = d_i;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pft_fifo.sv
module pft_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_i) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_d = ptr_inc(rd_ptr_q);
      count_d = count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !flush_i) mem[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem[rd_ptr_q];
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign count_o = count_q;
endmodule

// File: rtl/pft_engine.sv
module pft_engine
  import pft_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          empty_i,
  input  logic          busy_s_i,
  input  logic [DW-1:0] head_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] width_i,
  input  logic [TW-1:0] hold_i,
  output logic          pop_o,
  output logic [DW-1:0] pd_o,
  output logic          stb_n_o
);
  pft_state_e    state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] pd_q;
  logic          stb_n_q, stb_n_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pop_o   = 1'b0;
    if (!active_i) begin
      state_d = PFT_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PFT_IDLE: begin
          if (!empty_i && !busy_s_i) begin
            pop_o   = 1'b1;
            state_d = PFT_SETUP;
            cnt_d   = setup_i;
          end
        end
        PFT_SETUP: begin
          if (cnt_zero) begin
            state_d = PFT_STROBE;
            cnt_d   = width_i;
          end else begin
            cnt_d = cnt_q - TW'(1);
          end
        end
        PFT_STROBE: begin
          if (cnt_zero) begin
            state_d = PFT_HOLD;
            cnt_d   = hold_i;
          end else begin
            cnt_d = cnt_q - TW'(1);
          end
        end
        PFT_HOLD: begin
          if (cnt_zero) state_d = PFT_IDLE;
          else          cnt_d = cnt_q - TW'(1);
        end
        default: state_d = PFT_IDLE;
      endcase
    end
    stb_n_d = (state_d != PFT_STROBE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PFT_IDLE;
      cnt_q   <= '0;
      stb_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stb_n_q <= stb_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pd_q <= '0;
    else if (pop_o) pd_q <= head_i;
  end

  assign pd_o    = pd_q;
  assign stb_n_o = stb_n_q;
endmodule

// File: rtl/pfifo_tx.sv
module pfifo_tx
  import pft_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int TIME_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              dma_req_o,
  input  logic [TIME_W-1:0] setup_cyc_i,
  input  logic [TIME_W-1:0] width_cyc_i,
  input  logic [TIME_W-1:0] hold_cyc_i,
  input  logic              busy_i,
  output logic [DATA_W-1:0] pd_o,
  output logic              stb_n_o
);
  logic              active;
  logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic [DATA_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_count;
  logic              busy_s;

  assign active    = (mode_i == PFT_MODE_FIFO);
  assign fifo_push = wr_en_i && active && !fifo_full;
  assign dma_req_o = active && !fifo_full;

  pft_sync #(.STAGES(2), .RST_VAL(1'b1)) u_busy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (busy_i),
    .q_o   (busy_s)
  );

  pft_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (!active),
    .push_i  (fifo_push),
    .data_i  (wr_data_i),
    .pop_i   (fifo_pop),
    .data_o  (fifo_head),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .count_o (fifo_count)
  );

  pft_engine #(.DW(DATA_W), .TW(TIME_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .empty_i  (fifo_empty),
    .busy_s_i (busy_s),
    .head_i   (fifo_head),
    .setup_i  (setup_cyc_i),
    .width_i  (width_cyc_i),
    .hold_i   (hold_cyc_i),
    .pop_o    (fifo_pop),
    .pd_o     (pd_o),
    .stb_n_o  (stb_n_o)
  );
endmodule

// File: rtl/pfifo_tx_chk.sv
module pfifo_tx_chk #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int TIME_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_i,
  input logic              busy_i,
  input logic              dma_req_o,
  input logic              stb_n_o,
  input logic [DATA_W-1:0] pd_o,
  input logic [TIME_W-1:0] width_cyc_i,
  input logic              pop_i,
  input logic [CNT_W-1:0]  count_i
);
  logic [TIME_W:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt_q <= '0;
    else if (!stb_n_o) low_cnt_q <= low_cnt_q + 1'b1;
    else               low_cnt_q <= '0;
  end

  p_inactive_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 3'b101) |=> stb_n_o);

  p_full_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == CNT_W'(FIFO_DEPTH)) |-> !dma_req_o);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_i <= CNT_W'(FIFO_DEPTH));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n_o |-> $stable(pd_o));

  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n_o |-> (low_cnt_q <= {1'b0, width_cyc_i}));

  p_launch_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !$past(busy_i, 2));
endmodule

bind pfifo_tx pfifo_tx_chk #(
  .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .TIME_W(TIME_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .busy_i      (busy_i),
  .dma_req_o   (dma_req_o),
  .stb_n_o     (stb_n_o),
  .pd_o        (pd_o),
  .width_cyc_i (width_cyc_i),
  .pop_i       (fifo_pop),
  .count_i     (fifo_count)
);

// File: tb/pfifo_tx_bench.sv
module pfifo_tx_bench;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int TW = 8;
  localparam int NV = 6;
  // each vector: {setup, width, hold, data}
  localparam logic [31:0] VEC [NV] = '{
    32'h00_00_00_11, 32'h01_02_00_22, 32'h03_00_05_33,
    32'h05_04_02_44, 32'h00_07_01_55, 32'h02_01_03_66
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    mode;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          dma_req;
  logic [TW-1:0] setup_c, width_c, hold_c;
  logic          busy;
  logic [DW-1:0] pd;
  logic          stb_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_pd, t_fall, t_rise, gap;
  int n_pd = 0, n_fall = 0, n_rise = 0;
  logic [DW-1:0] cap [64];
  logic [DW-1:0] prev_pd;
  logic          prev_stb;
  logic          mon_on = 1'b0;

  always #4 clk = ~clk;

  pfifo_tx #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .TIME_W(TW)) u_pfifo_tx (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .dma_req_o(dma_req), .setup_cyc_i(setup_c),
    .width_cyc_i(width_c), .hold_cyc_i(hold_c), .busy_i(busy),
    .pd_o(pd), .stb_n_o(stb_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_on) begin
      if (pd !== prev_pd) begin
        t_pd = cyc; gap = cyc - t_rise; n_pd++;
      end
      if (prev_stb && !stb_n) begin
        t_fall = cyc; cap[n_fall % 64] = pd; n_fall++;
      end
      if (!prev_stb && stb_n) begin
        t_rise = cyc; n_rise++;
      end
    end
    prev_pd  = pd;
    prev_stb = stb_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rises(input int target);
    int guard = 0;
    while (n_rise < target && guard < 20000) begin
      @(negedge clk); guard++;
    end
    if (n_rise < target) begin
      errors++;
      $display("FAIL watchdog waiting for strobe: actual %0d expected %0d", n_rise, target);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, c0;
    rst_n = 1'b0; mode = 3'b101; wr_en = 1'b0; wr_data = '0;
    setup_c = '0; width_c = '0; hold_c = '0; busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R8 reset strobe high", int'(stb_n), 1);
    chk("R8 reset data zero", int'(pd), 0);
    chk("R2 reset dma request", int'(dma_req), 1);
    mon_on = 1'b1;
    repeat (3) @(negedge clk);

    // vector table: timing per transfer (R4, R5)
    for (int i = 0; i < NV; i++) begin
      setup_c = VEC[i][31:24]; width_c = VEC[i][23:16]; hold_c = VEC[i][15:8];
      base = n_rise;
      push(VEC[i][7:0]);
      wait_rises(base + 1);
      chk("R4 byte on lines at strobe", int'(cap[(n_fall - 1) % 64]), int'(VEC[i][7:0]));
      chk("R4 setup edges", t_fall - t_pd, int'(VEC[i][31:24]) + 1);
      chk("R5 strobe low cycles", t_rise - t_fall, int'(VEC[i][23:16]) + 1);
      repeat (int'(VEC[i][15:8]) + 4) @(negedge clk);
    end

    // fill while busy: R2, R3, R7
    busy = 1'b1;
    repeat (4) @(negedge clk);
    setup_c = 8'd1; width_c = 8'd2; hold_c = 8'd3;
    base = n_rise;
    push(8'hA1); push(8'hA2); push(8'hA3);
    chk("R2 request while room left", int'(dma_req), 1);
    push(8'hA4);
    chk("R2 request low when full", int'(dma_req), 0);
    push(8'hA5);
    repeat (20) @(negedge clk);
    chk("R7 no launch while busy", n_fall, base);
    c0 = cyc;
    busy = 1'b0;
    wait_rises(base + 1);
    chk("R7 launch three edges after busy falls", t_pd - c0, 3);
    wait_rises(base + 4);
    chk("R6 next data hold+2 after rise", gap, 5);
    for (int k = 0; k < 4; k++)
      chk("R3 write order", int'(cap[(base + k) % 64]), int'(8'hA1) + k);
    repeat (30) @(negedge clk);
    chk("R3 write while full dropped", n_fall, base + 4);
    chk("R8 idle strobe high", int'(stb_n), 1);
    chk("R8 last byte held", int'(pd), int'(8'hA4));
    chk("R2 request back after drain", int'(dma_req), 1);

    // mode exit flushes queue: R1
    busy = 1'b1;
    repeat (3) @(negedge clk);
    base = n_fall;
    push(8'hC1);
    mode = 3'b000;
    #1;
    chk("R1 no request when inactive", int'(dma_req), 0);
    @(negedge clk);
    push(8'hC2);
    mode = 3'b101;
    busy = 1'b0;
    repeat (40) @(negedge clk);
    chk("R1 queued and inactive writes discarded", n_fall, base);
    chk("R1 data lines untouched", int'(pd), int'(8'hA4));

    // mode exit during a strobe: R1
    setup_c = 8'd0; width_c = 8'd40; hold_c = 8'd0;
    base = n_fall;
    push(8'hD1);
    while (n_fall == base) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R5 strobe still low mid pulse", int'(stb_n), 0);
    mode = 3'b011;
    @(negedge clk);
    chk("R1 strobe released on mode exit", int'(stb_n), 1);
    mode = 3'b101;
    repeat (10) @(negedge clk);
    chk("R8 stays idle after abort", int'(stb_n), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule